// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit

This unit computes a 32x32 integer product and returns one 32-bit word of it. A register-form operation chooses the word with its function field. It can return the low word of the product, or the high word under one of three signedness rules: both operands signed, both unsigned, or the first operand signed and the second unsigned. An immediate-form operation multiplies the first operand by a sign-extended 16-bit constant and returns the low word. An operation with an unrecognised opcode or function code returns zero and raises an illegal flag beside the result.

Operations enter on a valid/ready handshake. A request is taken in any cycle where `in_valid` and `in_ready` are both high. Its result appears two cycles later on `out_valid`, and results leave in the order their requests were taken. The output side also uses valid/ready. While `out_valid` is high and `out_ready` is low, the result is held unchanged and the whole pipeline stalls, so `in_ready` drops. When the output slot is empty or is being drained, `in_ready` is high, and the unit takes one operation per cycle.

Top module: `mulu_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` and `out_illegal` are 0.
- R2: Register form (opcode 010000) with function 00000000000 returns bits 31:0 of `in_ra` times `in_rb`.
- R3: Register form with function 00000000001 returns bits 63:32 of the product, with both operands taken as two's-complement values.
- R4: Register form with function 00000000011 returns bits 63:32 of the product, with both operands taken as unsigned values.
- R5: Register form with function 00000000010 returns bits 63:32 of the product, with `in_ra` signed and `in_rb` unsigned.
- R6: Immediate form (opcode 011000) returns bits 31:0 of `in_ra` times the sign-extended 16-bit `in_imm`. In this form `in_func` and `in_rb` have no effect on the result.
- R7: Any other opcode, or a register-form function outside the four codes above, gives `out_rd` = 0 with `out_illegal` = 1. Every legal operation gives `out_illegal` = 0.
- R8: With `out_ready` held high, a request accepted in cycle n shows its result with `out_valid` high in cycle n+2. One result is produced per accepted request, in acceptance order, and back-to-back requests give back-to-back results.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_rd` and `out_illegal` stay unchanged until the result is taken.
- R10: `in_ready` is 1 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_opcode | input | 6 | Operation major code |
| in_func | input | 11 | Variant selector for the register form |
| in_ra | input | 32 | First operand |
| in_rb | input | 32 | Second operand (register form) |
| in_imm | input | 16 | Constant operand (immediate form) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_rd | output | 32 | Selected product word |
| out_illegal | output | 1 | Request was not a defined operation |

## Verification
The case to watch is a cycle where the held result is released and a new request is accepted at the same time. This happens whenever `out_ready` rises while a result is waiting and `in_valid` is already high. The bench provokes it by streaming requests without gaps while toggling `out_ready` at random. It judges the outcome with the scoreboard: no result may be lost or duplicated, every result must arrive in acceptance order with the expected word, and a result must not change while it is held.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  localparam int OPC_W  = 6;
  localparam int FUNC_W = 11;

  // major codes
  localparam logic [OPC_W-1:0]  OPC_MUL_REG = 6'b010000;
  localparam logic [OPC_W-1:0]  OPC_MUL_IMM = 6'b011000;

  // register-form variant selectors
  localparam logic [FUNC_W-1:0] FN_LO  = 11'd0;
  localparam logic [FUNC_W-1:0] FN_HSS = 11'd1;
  localparam logic [FUNC_W-1:0] FN_HSU = 11'd2;
  localparam logic [FUNC_W-1:0] FN_HUU = 11'd3;

  typedef enum logic [1:0] {MK_LO, MK_HSS, MK_HUU, MK_HSU} mul_kind_e;
endpackage

// File: rtl/mulu_decode.sv
module mulu_decode
  import mulu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FUNC_W-1:0] func,
  input  logic [W-1:0]      ra,
  input  logic [W-1:0]      rb,
  input  logic [IMM_W-1:0]  imm,
  output logic signed [W:0] a_ext,
  output logic signed [W:0] b_ext,
  output logic              take_high,
  output logic              illegal
);
  localparam int PAD = W - IMM_W;

  mul_kind_e   kind;
  logic        a_sgn;
  logic        b_sgn;
  logic [W-1:0] b_word;

  always_comb begin
    kind    = MK_LO;
    illegal = 1'b0;
    b_word  = rb;
    if (opcode == OPC_MUL_IMM) begin
      b_word = {{PAD{imm[IMM_W-1]}}, imm};
    end else if (opcode == OPC_MUL_REG) begin
      unique case (func)
        FN_LO:   kind = MK_LO;
        FN_HSS:  kind = MK_HSS;
        FN_HUU:  kind = MK_HUU;
        FN_HSU:  kind = MK_HSU;
        default: illegal = 1'b1;
      endcase
    end else begin
      illegal = 1'b1;
    end
  end

  // Low word does not depend on signedness; the immediate is always signed.
  assign a_sgn     = (kind == MK_HSS) || (kind == MK_HSU) || (kind == MK_LO);
  assign b_sgn     = (kind == MK_HSS) || (kind == MK_LO);
  assign take_high = (kind != MK_LO);

  // Illegal requests multiply zero by zero, giving a zero result.
  always_comb begin
    if (illegal) begin
      a_ext = '0;
      b_ext = '0;
    end else begin
      a_ext = {a_sgn & ra[W-1], ra};
      b_ext = {b_sgn & b_word[W-1], b_word};
    end
  end
endmodule

// File: rtl/mulu_core.sv
module mulu_core #(
  parameter int W = 32
) (
  input  logic signed [W:0] a_ext,
  input  logic signed [W:0] b_ext,
  input  logic              take_high,
  output logic [W-1:0]      rd
);
  localparam int PW = 2 * W + 2;

  logic signed [PW-1:0] prod;
  logic                 unused_guard;

  assign prod         = PW'(a_ext) * PW'(b_ext);
  assign unused_guard = ^prod[PW-1:2*W];
  assign rd           = take_high ? prod[2*W-1:W] : prod[W-1:0];
endmodule

// File: rtl/mulu_top.sv
module mulu_top
  import mulu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [W-1:0]      in_ra,
  input  logic [W-1:0]      in_rb,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_rd,
  output logic              out_illegal
);
  logic signed [W:0] dec_a, dec_b;
  logic              dec_high, dec_ill;

  logic              s1_v;
  logic signed [W:0] s1_a, s1_b;
  logic              s1_high, s1_ill;

  logic [W-1:0]      core_rd;
  logic              s2_v;
  logic [W-1:0]      s2_rd;
  logic              s2_ill;
  logic              advance;

  mulu_decode #(.W(W), .IMM_W(IMM_W)) u_dec (
    .opcode    (in_opcode),
    .func      (in_func),
    .ra        (in_ra),
    .rb        (in_rb),
    .imm       (in_imm),
    .a_ext     (dec_a),
    .b_ext     (dec_b),
    .take_high (dec_high),
    .illegal   (dec_ill)
  );

  // Whole pipe moves together; it freezes only while a result is refused.
  assign advance  = !s2_v || out_ready;
  assign in_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_high <= 1'b0;
      s1_ill  <= 1'b0;
    end else if (advance) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_a    <= dec_a;
        s1_b    <= dec_b;
        s1_high <= dec_high;
        s1_ill  <= dec_ill;
      end
    end
  end

  mulu_core #(.W(W)) u_core (
    .a_ext     (s1_a),
    .b_ext     (s1_b),
    .take_high (s1_high),
    .rd        (core_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_rd  <= '0;
      s2_ill <= 1'b0;
    end else if (advance) begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_rd  <= core_rd;
        s2_ill <= s1_ill;
      end
    end
  end

  assign out_valid   = s2_v;
  assign out_rd      = s2_rd;
  assign out_illegal = s2_ill;
endmodule

// File: rtl/mulu_chk.sv
module mulu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_rd,
  input logic         out_illegal
);
  logic [2:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'((in_valid && in_ready) ? 1 : 0)
                              - 3'((out_valid && out_ready) ? 1 : 0);
  end

  // R9: refused result is held and input is blocked
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rd) && $stable(out_illegal)));
  a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R10: empty output slot always takes work
  a_r10_free: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R7: illegal results are zero
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_rd == '0));
  // R8: never more than two operations in flight, no result without a request
  a_r8_depth: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd2);
  a_r8_nophantom: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == 3'd0) |-> !out_valid);
endmodule

bind mulu_top mulu_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_rd      (out_rd),
  .out_illegal (out_illegal)
);

// File: tb/sim_mulu_top.sv
module sim_mulu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [5:0]  in_opcode;
  logic [10:0] in_func;
  logic [31:0] in_ra, in_rb;
  logic [15:0] in_imm;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_rd;
  logic        out_illegal;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit bp_mode = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] rd;
    logic        ill;
    int          cyc;
    bit          lat;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;   // 50 MHz

  mulu_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_func(in_func), .in_ra(in_ra), .in_rb(in_rb),
    .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_rd(out_rd), .out_illegal(out_illegal)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent reference: 64-bit arithmetic on explicitly extended words.
  function automatic exp_t model(logic [5:0] op, logic [10:0] fn,
                                 logic [31:0] ra, logic [31:0] rb, logic [15:0] imm);
    exp_t e;
    longint sa, sb, ua, ub, si, p;
    sa = {{32{ra[31]}}, ra};
    sb = {{32{rb[31]}}, rb};
    ua = {32'b0, ra};
    ub = {32'b0, rb};
    si = {{48{imm[15]}}, imm};
    e.rd = '0; e.ill = 1'b0; e.cyc = 0; e.lat = 0; e.tag = "R7";
    if (op == 6'b011000) begin
      p = sa * si; e.rd = p[31:0]; e.tag = "R6";
    end else if (op == 6'b010000) begin
      case (fn)
        11'd0: begin p = ua * ub; e.rd = p[31:0];  e.tag = "R2"; end
        11'd1: begin p = sa * sb; e.rd = p[63:32]; e.tag = "R3"; end
        11'd3: begin p = ua * ub; e.rd = p[63:32]; e.tag = "R4"; end
        11'd2: begin p = sa * ub; e.rd = p[63:32]; e.tag = "R5"; end
        default: e.ill = 1'b1;
      endcase
    end else begin
      e.ill = 1'b1;
    end
    return e;
  endfunction

  task automatic issue(logic [5:0] op, logic [10:0] fn,
                       logic [31:0] ra, logic [31:0] rb, logic [15:0] imm);
    exp_t e;
    e = model(op, fn, ra, rb, imm);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_func = fn;
    in_ra = ra; in_rb = rb; in_imm = imm;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.cyc = cyc;
    e.lat = !bp_mode;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(1);
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst_n) out_ready <= 1'b1;
    else out_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  // Monitor / scoreboard
  bit          held = 0;
  logic [31:0] held_rd;
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (!out_valid) begin
        check(in_ready === 1'b1, "R10 in_ready while empty", {31'b0, in_ready}, 32'd1);
        held = 0;
      end else if (!out_ready) begin
        check(!in_ready, "R9 in_ready during stall", {31'b0, in_ready}, 32'd0);
        if (held) check(out_rd == held_rd, "R9 held result", out_rd, held_rd);
        held = 1; held_rd = out_rd;
      end else begin
        if (held) check(out_rd == held_rd, "R9 held result at release", out_rd, held_rd);
        held = 0;
        if (sb.size() == 0) begin
          check(0, "R8 unexpected result", out_rd, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_rd == e.rd, {e.tag, " result word"}, out_rd, e.rd);
          check(out_illegal == e.ill, {e.tag, " illegal flag (R7)"},
                {31'b0, out_illegal}, {31'b0, e.ill});
          if (e.lat)
            check(cyc - e.cyc == 2, "R8 latency", 32'(cyc - e.cyc), 32'd2);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 60000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_func = '0;
    in_ra = '0; in_rb = '0; in_imm = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check(out_illegal == 1'b0, "R1 out_illegal in reset", {31'b0, out_illegal}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'b0, out_valid}, 32'd0);

    // R8: isolated request, then back-to-back
    issue(6'b010000, 11'd0, 32'd7, 32'd6, 16'd0);
    idle(4);
    // R2..R5 corner operands, back-to-back
    for (int k = 0; k < 4; k++) begin
      logic [10:0] fn;
      fn = 11'(k);
      issue(6'b010000, fn, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0);
      issue(6'b010000, fn, 32'h8000_0000, 32'h8000_0000, 16'd0);
      issue(6'b010000, fn, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'd0);
      issue(6'b010000, fn, 32'h8000_0000, 32'hFFFF_FFFF, 16'd0);
      issue(6'b010000, fn, 32'h1234_5678, 32'h0000_0000, 16'd0);
    end
    // R6: immediate, func and rb ignored
    issue(6'b011000, 11'h7FF, 32'h0001_0003, 32'hDEAD_BEEF, 16'hFFFE);
    issue(6'b011000, 11'h001, 32'h8000_0001, 32'h1111_1111, 16'h7FFF);
    issue(6'b011000, 11'h003, 32'hFFFF_FFFF, 32'h0, 16'h8000);
    // R7: illegal function codes and opcodes
    issue(6'b010000, 11'd4, 32'h5, 32'h6, 16'd0);
    issue(6'b010000, 11'h400, 32'hFFFF_FFFF, 32'h3, 16'd0);
    issue(6'b010001, 11'd0, 32'h9, 32'h9, 16'd9);
    issue(6'b000000, 11'd1, 32'h9, 32'h9, 16'd9);
    drain();

    // Random stream, no back-pressure
    for (int i = 0; i < 150; i++)
      issue(($urandom % 8 == 0) ? 6'b011000 : 6'b010000, 11'($urandom % 5),
            $urandom, $urandom, 16'($urandom));
    drain();

    // R9/R10: random stream under back-pressure, release collides with accept
    bp_mode = 1;
    for (int i = 0; i < 300; i++)
      issue(($urandom % 6 == 0) ? 6'b011000 : 6'b010000, 11'($urandom % 5),
            $urandom, $urandom, 16'($urandom));
    drain();
    bp_mode = 0;
    repeat (3) @(negedge clk);
    #2;
    check(sb.size() == 0, "R8 all results delivered", 32'(sb.size()), 32'd0);
    check(out_valid == 1'b0, "R8 no extra result", {31'b0, out_valid}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule